// File: doc/BRIEF.md
# Table-Driven Pin Event Sequencer

This block watches one or two input pins and, on every clock, chooses an action for a 16-bit accumulator from a small programmable table. It first passes the pins through a synchronizer. It then forms a 2-bit selector from them and adds a 1-bit state to the selector. The selector and state pick one of eight 5-bit opcodes. Software fills two 32-bit table words, one for each state value, and a 16-bit signed step value, all through a simple write port.

The selector is built in one of two ways. In edge mode it is the previous and current level of pin A, so rising edges, falling edges and steady levels each pick their own action. In pair mode it is the current level of pin B next to the current level of pin A, so the live combination of the two pins picks the action. The opcodes can hold, count up, count down, add the step, clear, flip the state, count and flip together, or publish the accumulator. Publishing copies the accumulator into a holding register and raises a one-cycle strobe.

Top module: `pin_evt_seq`

## Requirements
- R1: After synchronous reset, acc_o, held_o, state_o and upd_o are all zero, and both tables and the step register are zero, so every opcode is hold.
- R2: Each pin passes through two synchronizer flops. With bit 26 of table word 0 clear, the selector is {A previous, A current}, and the previous level is zero after reset. A pin that is already high when reset is released therefore counts as exactly one rising transition (selector 01).
- R3: With bit 26 of table word 0 set, the selector is {B current, A current}. The action depends on the pin combination and not on transitions of A.
- R4: In state 0 the opcode comes from table word 0 and in state 1 from table word 1. In both words, selector 00 uses bits [4:0], 01 uses [9:5], 10 uses [14:10] and 11 uses [19:15].
- R5: Opcode 0 holds, 1 adds one, 2 subtracts one and 4 clears the accumulator. All arithmetic wraps modulo 2^16.
- R6: Opcode 3 adds the step register, read as a two's complement 16-bit value, with wrap-around.
- R7: Opcode 5 inverts the state. Opcode 6 adds one to the accumulator and inverts the state in the same cycle.
- R8: Opcode 7 copies the accumulator into held_o and raises upd_o for exactly one cycle, leaving the accumulator unchanged. upd_o is low in every other cycle.
- R9: Opcode values 8 through 31 behave as hold.
- R10: A write on cfg_addr 0 (table word 0), 1 (table word 1) or 2 (step, low 16 bits of cfg_wdata) takes effect at the next edge. An opcode executed in the same cycle as the write uses the old contents. Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Asynchronous input pin A |
| pin_b | input | 1 | Asynchronous input pin B |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | 0 table word 0, 1 table word 1, 2 step, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| acc_o | output | 16 | Live accumulator |
| held_o | output | 16 | Accumulator value captured by the last publish opcode |
| upd_o | output | 1 | One-cycle publish strobe |
| state_o | output | 1 | Current state bit |

## Verification
A table or step write can land in the same clock as the lookup that reads that entry. The bench holds the pins steady so that a counting or step-adding entry runs on every clock. It then writes a new entry or step on exactly one cycle and samples the accumulator on the two following cycles. The first sample must show the old action and the second the new one, which tells whether the write raced ahead of the lookup.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int OPC_W   = 5;
    localparam int TBL_W   = 32;
    localparam int PAIR_BIT = 26;

    typedef enum logic [1:0] {
        CFG_TBL0 = 2'd0,
        CFG_TBL1 = 2'd1,
        CFG_STEP = 2'd2,
        CFG_NONE = 2'd3
    } cfg_addr_e;

    typedef enum logic [2:0] {
        OP_HOLD    = 3'd0,
        OP_INC     = 3'd1,
        OP_DEC     = 3'd2,
        OP_ADD     = 3'd3,
        OP_CLR     = 3'd4,
        OP_TOG     = 3'd5,
        OP_INC_TOG = 3'd6,
        OP_PUB     = 3'd7
    } op_e;

    function automatic op_e decode_op(input logic [OPC_W-1:0] code);
        if (code > OPC_W'(7)) return OP_HOLD;
        return op_e'(code[2:0]);
    endfunction

    function automatic logic [OPC_W-1:0] pick_field(input logic [TBL_W-1:0] word,
                                                    input logic [1:0] sel);
        return word[sel*OPC_W +: OPC_W];
    endfunction

endpackage

// File: rtl/pin_evt_sync.sv
module pin_evt_sync #(
    parameter int NPINS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_in,
    output logic [NPINS-1:0] cur_o,
    output logic [NPINS-1:0] prev_o
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins_in[p]};
                prev_q  <= chain_q[STAGES-1];
            end
        end
        assign cur_o[p]  = chain_q[STAGES-1];
        assign prev_o[p] = prev_q;
    end
endmodule

// File: rtl/pin_evt_cfg.sv
module pin_evt_cfg
    import pin_evt_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [TBL_W-1:0] wdata,
    input  logic [1:0]       sel,
    input  logic             state,
    output op_e              op_o,
    output logic [ACC_W-1:0] step_o,
    output logic             pair_o
);
    logic [TBL_W-1:0] tbl0_q, tbl1_q;
    logic [ACC_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl0_q <= '0;
            tbl1_q <= '0;
            step_q <= '0;
        end else if (we) begin
            unique case (cfg_addr_e'(addr))
                CFG_TBL0: tbl0_q <= wdata;
                CFG_TBL1: tbl1_q <= wdata;
                CFG_STEP: step_q <= wdata[ACC_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        op_o = decode_op(pick_field(state ? tbl1_q : tbl0_q, sel));
    end

    assign step_o = step_q;
    assign pair_o = tbl0_q[PAIR_BIT];
endmodule

// File: rtl/pin_evt_core.sv
module pin_evt_core
    import pin_evt_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] held_o,
    output logic             upd_o,
    output logic             state_o
);
    logic [ACC_W-1:0] acc_q, held_q;
    logic             state_q, upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            held_q  <= '0;
            state_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            unique case (op)
                OP_INC:     acc_q <= acc_q + ACC_W'(1);
                OP_DEC:     acc_q <= acc_q - ACC_W'(1);
                OP_ADD:     acc_q <= acc_q + step;
                OP_CLR:     acc_q <= '0;
                OP_TOG:     state_q <= ~state_q;
                OP_INC_TOG: begin
                    acc_q   <= acc_q + ACC_W'(1);
                    state_q <= ~state_q;
                end
                OP_PUB: begin
                    held_q <= acc_q;
                    upd_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign acc_o   = acc_q;
    assign held_o  = held_q;
    assign upd_o   = upd_q;
    assign state_o = state_q;

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> (acc_q == $past(acc_q) && state_q == $past(state_q)));
    assert_inc_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC) |=> (acc_q == $past(acc_q) + ACC_W'(1)));
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |=> (acc_q == '0));
    assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TOG || op == OP_INC_TOG) |=> (state_q != $past(state_q)));
    assert_publish_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUB) |=> (upd_q && held_q == $past(acc_q) && acc_q == $past(acc_q)));
    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (op != OP_PUB) |=> !upd_q);
endmodule

// File: rtl/pin_evt_seq.sv
module pin_evt_seq
    import pin_evt_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] held_o,
    output logic             upd_o,
    output logic             state_o
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] cur, prev;
    logic [1:0]       sel;
    logic             pair;
    op_e              op;
    logic [ACC_W-1:0] step;

    pin_evt_sync #(.NPINS(NPINS), .STAGES(SYNC_ST)) u_sync (
        .clk(clk), .rst(rst), .pins_in({pin_b, pin_a}),
        .cur_o(cur), .prev_o(prev)
    );

    always_comb begin
        sel = {pair ? cur[1] : prev[0], cur[0]};
    end

    pin_evt_cfg #(.ACC_W(ACC_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .sel(sel), .state(state_o), .op_o(op), .step_o(step), .pair_o(pair)
    );

    pin_evt_core #(.ACC_W(ACC_W)) u_core (
        .clk(clk), .rst(rst), .op(op), .step(step),
        .acc_o(acc_o), .held_o(held_o), .upd_o(upd_o), .state_o(state_o)
    );

    assert_edge_sel_R2: assert property (@(posedge clk) disable iff (rst)
        !pair |-> (sel[1] == $past(sel[0])));
endmodule

// File: tb/pin_evt_seq_tb_top.sv
module pin_evt_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_a = 1'b0, pin_b = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] acc_o, held_o;
    logic        upd_o, state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_evt_seq dut_i (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_o(acc_o), .held_o(held_o), .upd_o(upd_o), .state_o(state_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        pin_a = a; pin_b = b; rst = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] addr, input logic [31:0] data);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            pin_a = 1'b1; cycles(4);
            pin_a = 1'b0; cycles(4);
        end
    endtask

    task automatic test_reset;
        do_reset(1'b1, 1'b0);
        check("R1 acc", acc_o, 0);
        check("R1 held", held_o, 0);
        check("R1 upd", upd_o, 0);
        check("R1 state", state_o, 0);
        cfg_write(2'd0, 32'd1 << 5);
        cycles(6);
        check("R2 high pin at reset release counts once", acc_o, 1);
    endtask

    task automatic test_count;
        do_reset(1'b0, 1'b0);
        cfg_write(2'd0, (32'd1 << 5));
        pulse_a(3);
        check("R4 rising entry counts up", acc_o, 3);
        cfg_write(2'd0, (32'd2 << 10));
        pulse_a(5);
        check("R5 falling entry counts down with wrap", acc_o, 16'hFFFE);
        cfg_write(2'd0, 32'd4);
        cycles(3);
        check("R5 clear on low level", acc_o, 0);
    endtask

    task automatic test_step;
        do_reset(1'b0, 1'b0);
        cfg_write(2'd2, 32'h0000_FFFD);
        cfg_write(2'd0, (32'd3 << 5));
        pulse_a(2);
        check("R6 negative step", acc_o, 16'hFFFA);
        cfg_write(2'd2, 32'd7);
        pulse_a(1);
        check("R6 positive step wraps", acc_o, 16'h0001);
    endtask

    task automatic test_state;
        do_reset(1'b0, 1'b0);
        cfg_write(2'd0, (32'd5 << 5) | (32'd2 << 10));
        cfg_write(2'd1, (32'd6 << 10));
        pin_a = 1'b1; cycles(5);
        check("R7 toggle enters state 1", state_o, 1);
        check("R7 toggle leaves acc", acc_o, 0);
        pin_a = 1'b0; cycles(5);
        check("R4 state 1 uses word 1 (inc-toggle)", acc_o, 1);
        check("R7 inc-toggle returns to state 0", state_o, 0);
    endtask

    task automatic test_pair;
        do_reset(1'b0, 1'b0);
        cfg_write(2'd0, (32'd1 << 26) | (32'd1 << 15));
        pin_a = 1'b1; cycles(6);
        check("R3 A alone does nothing in pair mode", acc_o, 0);
        pin_b = 1'b1; cycles(5);
        pin_a = 1'b0; pin_b = 1'b0; cycles(5);
        check("R3 both high for five cycles", acc_o, 5);
    endtask

    task automatic test_publish;
        int seen;
        do_reset(1'b0, 1'b0);
        cfg_write(2'd0, (32'd1 << 5) | (32'd7 << 10));
        pin_a = 1'b1; cycles(5);
        check("R8 no strobe before publish", upd_o, 0);
        pin_a = 1'b0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (upd_o) seen++;
        end
        check("R8 single strobe", seen, 1);
        check("R8 held value", held_o, 1);
        check("R8 acc unchanged", acc_o, 1);
    endtask

    task automatic test_high_codes;
        int seen;
        do_reset(1'b0, 1'b0);
        cfg_write(2'd0, 32'd31 | (32'd8 << 5) | (32'd17 << 10) | (32'd31 << 15));
        seen = 0;
        for (int i = 0; i < 2; i++) begin
            pin_a = ~pin_a;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (upd_o) seen++;
            end
        end
        check("R9 codes above 7 leave acc", acc_o, 0);
        check("R9 codes above 7 leave state", state_o, 0);
        check("R9 codes above 7 give no strobe", seen, 0);
    endtask

    task automatic test_same_cycle;
        int v0;
        do_reset(1'b1, 1'b0);
        cfg_write(2'd0, (32'd1 << 15));
        cycles(6);
        v0 = acc_o;
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 table write uses old entry in its cycle", acc_o, (v0 + 1) & 16'hFFFF);
        @(negedge clk);
        check("R10 new entry after write", acc_o, (v0 + 1) & 16'hFFFF);
        cfg_write(2'd2, 32'd1);
        cfg_write(2'd0, (32'd3 << 15));
        cycles(2);
        v0 = acc_o;
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'd16;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 step write uses old step in its cycle", acc_o, (v0 + 1) & 16'hFFFF);
        @(negedge clk);
        check("R10 new step after write", acc_o, (v0 + 17) & 16'hFFFF);
        cfg_write(2'd0, 32'd0);
        v0 = acc_o;
        cfg_write(2'd3, 32'hFFFF_FFFF);
        cycles(3);
        check("R10 address 3 ignored", acc_o, v0);
    endtask

    initial begin
        test_reset();
        test_count();
        test_step();
        test_state();
        test_pair();
        test_publish();
        test_high_codes();
        test_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule